// File: doc/BRIEF.md
# Three-Bus Register Datapath Core

This block is a small processor datapath built around three internal buses. Two read ports of a register file drive bus A and bus B, and those buses feed the two ALU inputs with no holding register in between. The ALU result travels on bus C straight into the single write port. The block has no A or C holding latches, so a register-to-register operation reads, computes and writes back within one step.

A three-state step sequencer runs every instruction in three clock cycles. In the first fetch step the program counter is copied to the memory address register, the word at that address is captured into the memory buffer register, and the program counter advances by one word. In the second fetch step the instruction register is loaded from the memory buffer register. The execute step then runs the operation, and the sequencer returns to the first fetch step. Memory is reached through an address output and a read-data input. The read path is combinational: the word for the address presented in a step is captured at the end of that same step.

The instruction set covers register-register add, subtract, AND, OR and a two-operand NOT. Each register write that completes is reported on registered outputs, one cycle after the write edge.

Top module: `tribus_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the step output is 0 (first fetch), the program counter is 0, the write-report valid output is low and every register holds 0.
- R2: The step output runs 0, 1, 2, 0, ... with one step per clock and no other value. Step codes are 0 = first fetch, 1 = second fetch, 2 = execute.
- R3: In step 0, `mem_addr` equals the program counter. The program counter grows by 4 (modulo 2^32) at the end of step 0 and holds its value in the other steps.
- R4: At the end of step 1, `ir_o` takes the word that `mem_rdata` returned for the address presented in the preceding step 0. `ir_o` does not change in any other step.
- R5: Instruction word fields: bits [31:28] are the opcode, [27:23] the destination ra, [22:18] the source rb, and [17:13] the source rc. Opcode 0 writes R[ra] = R[rb] + R[rc] and opcode 1 writes R[ra] = R[rb] - R[rc], both modulo 2^32.
- R6: Opcode 2 writes R[ra] = R[rb] AND R[rc]. Opcode 3 writes R[ra] = R[rb] OR R[rc].
- R7: Opcode 4 writes R[ra] = NOT R[rb]. The rc field has no effect on the result.
- R8: Opcodes 5 to 15 write no register, and the write-report valid output stays low for them.
- R9: A value written in one instruction's execute step is read by the next instruction's execute step, including when the destination is also a source.
- R10: A write made at the end of step 2 is reported on `wb_valid_o`, `wb_idx_o` and `wb_data_o` during the following step 0 only. At all other times `wb_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Memory address: the program counter in step 0, otherwise the memory address register |
| mem_rdata | input | 32 | Memory read word for `mem_addr`, valid in the same cycle |
| step_o | output | 2 | Current step code |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| wb_valid_o | output | 1 | A register was written at the last clock edge |
| wb_idx_o | output | 5 | Index of the register written |
| wb_data_o | output | 32 | Value written |

## Verification
A wrong register value stays hidden until a later instruction reads it. It then appears on `wb_data_o` in the step 0 that follows that instruction's execute step, so the program chains every result into later operands and the bench compares each write report with a behavioural model. A sequencer or program-counter fault shows within one cycle on `step_o`, `pc_o` or `mem_addr`. A fault in instruction capture shows on `ir_o` at the next step 1 edge, and again on the following write report.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

  typedef enum logic [1:0] {
    ST_FETCH_A = 2'd0,
    ST_FETCH_B = 2'd1,
    ST_EXEC    = 2'd2
  } step_e;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOT = 4'd4
  } op_e;

  localparam int OPC_W = 4;

endpackage

// File: rtl/tribus_stepgen.sv
module tribus_stepgen
  import tribus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output step_e step
);

  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_FETCH_A;
    end else begin
      unique case (step_q)
        ST_FETCH_A: step_q <= ST_FETCH_B;
        ST_FETCH_B: step_q <= ST_EXEC;
        default:    step_q <= ST_FETCH_A;
      endcase
    end
  end

  assign step = step_q;

  // R2: fixed three-step ring
  p_fetch_a_next_r2: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_FETCH_A) |=> (step_q == ST_FETCH_B));
  p_fetch_b_next_r2: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_FETCH_B) |=> (step_q == ST_EXEC));
  p_exec_next_r2: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_EXEC) |=> (step_q == ST_FETCH_A));

endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] regs_q [NREG];

  // Per-entry write logic; each entry clears on reset.
  for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[gi] <= '0;
      end else if (we && (waddr == AW'(gi))) begin
        regs_q[gi] <= wdata;
      end
    end
  end

  // Two asynchronous read ports: bus A and bus B.
  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  bus_a,
  input  logic [XLEN-1:0]  bus_b,
  output logic [XLEN-1:0]  bus_c,
  output logic             legal
);

  always_comb begin
    bus_c = '0;
    legal = 1'b1;
    unique case (opc)
      OP_ADD:  bus_c = bus_a + bus_b;
      OP_SUB:  bus_c = bus_a - bus_b;
      OP_AND:  bus_c = bus_a & bus_b;
      OP_OR:   bus_c = bus_a | bus_b;
      OP_NOT:  bus_c = ~bus_a;
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/tribus_core.sv
module tribus_core
  import tribus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int PC_INC = XLEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [1:0]      step_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ir_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_idx_o,
  output logic [XLEN-1:0] wb_data_o
);

  localparam int RA_MSB = XLEN - OPC_W - 1;
  localparam int RB_MSB = RA_MSB - AW;
  localparam int RC_MSB = RB_MSB - AW;

  step_e           step;
  logic [XLEN-1:0] pc_q, mar_q, mbr_q, ir_q;
  logic [OPC_W-1:0] opc;
  logic [AW-1:0]   fld_ra, fld_rb, fld_rc;
  logic [XLEN-1:0] bus_a, bus_b, bus_c;
  logic            op_legal, rf_we;
  logic            wb_valid_q;
  logic [AW-1:0]   wb_idx_q;
  logic [XLEN-1:0] wb_data_q;

  tribus_stepgen u_step (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  // Instruction fields
  assign opc    = ir_q[XLEN-1 -: OPC_W];
  assign fld_ra = ir_q[RA_MSB -: AW];
  assign fld_rb = ir_q[RB_MSB -: AW];
  assign fld_rc = ir_q[RC_MSB -: AW];

  tribus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (fld_ra),
    .wdata   (bus_c),
    .raddr_a (fld_rb),
    .rdata_a (bus_a),
    .raddr_b (fld_rc),
    .rdata_b (bus_b)
  );

  tribus_alu #(.XLEN(XLEN)) u_alu (
    .opc   (opc),
    .bus_a (bus_a),
    .bus_b (bus_b),
    .bus_c (bus_c),
    .legal (op_legal)
  );

  assign rf_we = (step == ST_EXEC) && op_legal;

  // Combinational memory path: the PC is presented during the first fetch step.
  assign mem_addr = (step == ST_FETCH_A) ? pc_q : mar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (step == ST_FETCH_A) begin
        mar_q <= pc_q;
        mbr_q <= mem_rdata;
        pc_q  <= pc_q + XLEN'(PC_INC);
      end
      if (step == ST_FETCH_B) begin
        ir_q <= mbr_q;
      end
    end
  end

  // Registered write report
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= rf_we;
      if (rf_we) begin
        wb_idx_q  <= fld_ra;
        wb_data_q <= bus_c;
      end
    end
  end

  assign step_o     = step;
  assign pc_o       = pc_q;
  assign ir_o       = ir_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_idx_o   = wb_idx_q;
  assign wb_data_o  = wb_data_q;

  // R3: PC moves only at the end of the first fetch step
  p_pc_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH_A) |=> (pc_q == $past(pc_q) + XLEN'(PC_INC)));
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (step != ST_FETCH_A) |=> $stable(pc_q));
  // R4: instruction register only loads in the second fetch step
  p_ir_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (step != ST_FETCH_B) |=> $stable(ir_q));
  // R10: write report only in the step after execute
  p_report_slot_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid_q |-> (step == ST_FETCH_A));
  // R8: no report for an unknown opcode
  p_illegal_silent_r8: assert property (@(posedge clk) disable iff (rst)
    ((step == ST_EXEC) && (opc > OPC_W'(OP_NOT))) |=> !wb_valid_q);

endmodule

// File: tb/tribus_core_tb.sv
`timescale 1ns/1ps
module tribus_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata;
  logic [1:0]  step_o;
  logic [31:0] pc_o, ir_o;
  logic        wb_valid_o;
  logic [4:0]  wb_idx_o;
  logic [31:0] wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] mem [32];

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[6:2]];

  tribus_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .step_o     (step_o),
    .pc_o       (pc_o),
    .ir_o       (ir_o),
    .wb_valid_o (wb_valid_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o)
  );

  function automatic logic [31:0] enc(input int op, input int ra, input int rb, input int rc);
    return {op[3:0], ra[4:0], rb[4:0], rc[4:0], 13'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  int          m_step;
  logic [31:0] m_pc, m_mbr, m_ir;
  logic [31:0] m_regs [32];
  logic        e_valid;
  logic [4:0]  e_idx;
  logic [31:0] e_data;
  string       e_tag;

  task automatic model_edge();
    int op, ra, rb, rc;
    logic [31:0] res;
    bit ok;
    e_valid = 1'b0;
    case (m_step)
      0: begin m_mbr = mem[m_pc[6:2]]; m_pc = m_pc + 32'd4; m_step = 1; end
      1: begin m_ir = m_mbr; m_step = 2; end
      default: begin
        op = int'(m_ir[31:28]); ra = int'(m_ir[27:23]);
        rb = int'(m_ir[22:18]); rc = int'(m_ir[17:13]);
        ok = 1'b1; res = 32'd0;
        case (op)
          0: begin res = m_regs[rb] + m_regs[rc]; e_tag = "R5 add"; end
          1: begin res = m_regs[rb] - m_regs[rc]; e_tag = "R5 sub"; end
          2: begin res = m_regs[rb] & m_regs[rc]; e_tag = "R6 and"; end
          3: begin res = m_regs[rb] | m_regs[rc]; e_tag = "R6 or";  end
          4: begin res = ~m_regs[rb];            e_tag = "R7 not"; end
          default: begin ok = 1'b0;             e_tag = "R8 illegal"; end
        endcase
        if (ok) begin
          m_regs[ra] = res;
          e_valid = 1'b1; e_idx = ra[4:0]; e_data = res;
        end
        m_step = 0;
      end
    endcase
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = enc(0, 0, 0, 0);
    mem[0]  = enc(4, 1, 0, 0);    // r1 = ~0
    mem[1]  = enc(0, 2, 1, 1);    // r2 = r1+r1 (R9 chain)
    mem[2]  = enc(1, 3, 0, 1);    // r3 = 0 - r1 = 1
    mem[3]  = enc(0, 4, 3, 3);    // r4 = 2
    mem[4]  = enc(3, 5, 4, 3);    // r5 = 3
    mem[5]  = enc(2, 6, 5, 2);    // r6 = 3 & fffffffe = 2
    mem[6]  = enc(4, 7, 5, 9);    // R7: rc nonzero, ignored
    mem[7]  = enc(1, 8, 3, 4);    // 1-2 wraps
    mem[8]  = enc(9, 10, 1, 1);   // R8 illegal
    mem[9]  = enc(15, 3, 1, 1);   // R8 illegal, r3 must stay 1
    mem[10] = enc(0, 9, 8, 3);    // ffffffff+1 wraps to 0
    mem[11] = enc(0, 10, 3, 0);   // r10 = r3 (proves r3 untouched)
    mem[12] = enc(1, 4, 4, 3);    // r4 = r4 - r3, dest is source
    mem[13] = enc(0, 31, 4, 5);   // r31 = 1 + 3
    mem[14] = enc(3, 11, 31, 6);  // reads r31
    mem[15] = enc(2, 12, 1, 7);   // ffffffff & ~3
  end

  initial begin
    m_step = 0; m_pc = '0; m_mbr = '0; m_ir = '0;
    e_valid = 1'b0; e_idx = '0; e_data = '0; e_tag = "";
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 step in reset", {30'b0, step_o}, 32'd0);
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 valid in reset", {31'b0, wb_valid_o}, 32'd0);
    rst = 1'b0;
    for (int cyc = 0; cyc < 20 * 3; cyc++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R2 step", {30'b0, step_o}, m_step[31:0]);
      chk("R3 pc", pc_o, m_pc);
      if (m_step == 0) chk("R3 mem_addr", mem_addr, m_pc);
      chk("R4 ir", ir_o, m_ir);
      chk(e_valid ? "R10 valid" : {e_tag == "R8 illegal" ? "R8" : "R10", " no write"},
          {31'b0, wb_valid_o}, {31'b0, e_valid});
      if (e_valid) begin
        chk({e_tag, " R9 idx"}, {27'b0, wb_idx_o}, {27'b0, e_idx});
        chk({e_tag, " R9 data"}, wb_data_o, e_data);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule